// File: doc/BRIEF.md
# Instruction-Framed SPI Register Slave

This block is the serial front end of an encoder counter. An SPI master (mode 0: SCK idles low) frames each transaction with an active-low select. The first byte of a transaction is an instruction. Any bytes after it carry data. The instruction names an operation and a target register. Depending on the operation, the block collects write data, shifts read data out, or acts at once on the instruction byte alone.

The block holds two 8-bit mode registers, a data register and an output register. It reaches the counter core through a small side port. The core supplies the live count and a status byte. The block sends back a counter-write pulse with a value, a counter-clear pulse and a status-clear pulse. SCK, select and MOSI are oversampled in the system clock domain. Every register update therefore happens in that domain, and only at a byte boundary.

The width field of the second mode register sets how many data bytes the data, counter and output registers use. Accesses to the mode and status registers always carry one data byte.

Top module: `spi_cmd_slave`

## Requirements
- R1: A transaction runs while `ss_n` is low. MOSI is taken MSB first on each rising SCK edge. MISO changes on falling SCK edges, and a register value is sent with its most significant transferred byte first.
- R2: In the instruction byte, bits [7:6] are the operation (00 clear, 01 read, 10 write, 11 load) and bits [5:3] are the target (0 mode0, 1 mode1, 2 data, 3 counter, 4 output, 5 status). Bits [2:0] are ignored. Targets 6 and 7 do nothing, and a read of them returns zeros.
- R3: The mode1 bits [1:0] select the width of the data, counter and output registers: 00 gives 4 bytes, 01 gives 3, 10 gives 2 and 11 gives 1. A narrow access uses the low bytes of the register. Mode and status accesses use one byte. The width is fixed when the instruction byte completes.
- R4: A write takes effect only after all of its expected bytes have arrived. All bytes commit together, and the value is zero-extended. A write that select cuts short changes nothing. A counter write gives one `cnt_wr` pulse carrying the value. Writes to the output and status registers are ignored.
- R5: Once the expected number of bytes has been transferred, further bytes have no effect until select goes high and then low again.
- R6: During a read, MOSI is ignored. The value sent is a snapshot taken when the instruction byte completes. After the expected bytes, MISO stays low.
- R7: Load counter gives a `cnt_wr` pulse carrying the data register. Load output copies `cnt_in` into the output register. Both act on the instruction byte alone.
- R8: Clear sets mode0, mode1, data or output to zero. Clear counter gives a `cnt_clr` pulse. Clear status gives a `stat_clr` pulse. At most one of the three pulses is high in any cycle.
- R9: While `ss_n` is high, `miso_oe` is low and `miso` is low.
- R10: After reset, all held registers are zero, no pulse is active and MISO is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n | input | 1 | Slave select, active low |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the MISO pad |
| cnt_in | input | 8*MAXB | Live count from the counter core |
| status_in | input | 8 | Status byte from the counter core |
| mode0 | output | 8 | Mode register 0 |
| mode1 | output | 8 | Mode register 1; bits [1:0] set the width |
| data_reg | output | 8*MAXB | Data register |
| out_reg | output | 8*MAXB | Output register (counter snapshot) |
| cnt_wr | output | 1 | One-cycle counter write strobe |
| cnt_wdata | output | 8*MAXB | Value to load into the counter |
| cnt_clr | output | 1 | One-cycle counter clear strobe |
| stat_clr | output | 1 | One-cycle status clear strobe |

## Verification
The bench builds the block with the default MAXB of 4. This lets the run step mode1 through every width from four bytes down to one, so that narrow reads and writes of the data, counter and output registers take their low bytes. A read that sends more data bytes than it expects, and a write to mode0 that carries a second byte, together cover the lock-out after the expected length. A transaction cut short, and a read during which the bench changes the live count, show that a commit happens only once the bytes are complete and that the value read is the one captured when the instruction completed.

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int MAXB = 4,
  localparam int DW = 8 * MAXB,
  localparam int CW = $clog2(MAXB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_n,
  input  logic          sck,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  input  logic [DW-1:0] cnt_in,
  input  logic [7:0]    status_in,
  output logic [7:0]    mode0,
  output logic [7:0]    mode1,
  output logic [DW-1:0] data_reg,
  output logic [DW-1:0] out_reg,
  output logic          cnt_wr,
  output logic [DW-1:0] cnt_wdata,
  output logic          cnt_clr,
  output logic          stat_clr
);
  typedef enum logic [1:0] {P_INS, P_RD, P_WR, P_END} phase_t;

  logic [2:0] sck_s, ss_s;
  logic [1:0] mosi_s;
  phase_t     phase;
  logic [2:0] bitc, rsel;
  logic [7:0] rxb;
  logic [CW-1:0] left;
  logic [DW-1:0] acc, sh, rd_val, rd_al;
  logic [CW-1:0] rd_len;
  logic       miso_r;

  wire rise   = sck_s[1] & ~sck_s[2];
  wire fall   = ~sck_s[1] & sck_s[2];
  wire active = ~ss_s[1];
  wire [7:0] byte_in = {rxb[6:0], mosi_s[1]};
  wire last   = rise & (bitc == 3'd7);
  wire [2:0] isel = byte_in[5:3];
  wire [CW-1:0] nb = CW'(MAXB) - CW'(mode1[1:0]);
  wire wide = (isel == 3'd2) || (isel == 3'd3) || (isel == 3'd4);
  wire [DW-1:0] wacc = {acc[DW-9:0], byte_in};

  assign miso = miso_r;
  assign miso_oe = active;

  always_comb begin
    case (isel)
      3'd0: rd_val = DW'(mode0);
      3'd1: rd_val = DW'(mode1);
      3'd2: rd_val = data_reg;
      3'd3: rd_val = cnt_in;
      3'd4: rd_val = out_reg;
      3'd5: rd_val = DW'(status_in);
      default: rd_val = '0;
    endcase
    rd_len = wide ? nb : CW'(1);
    rd_al = rd_val << (8 * (MAXB - int'(rd_len)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0; ss_s <= '1; mosi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck};
      ss_s <= {ss_s[1:0], ss_n};
      mosi_s <= {mosi_s[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_INS; bitc <= '0; rsel <= '0; rxb <= '0; left <= '0;
      acc <= '0; sh <= '0; miso_r <= 1'b0;
      mode0 <= '0; mode1 <= '0; data_reg <= '0; out_reg <= '0;
      cnt_wr <= 1'b0; cnt_wdata <= '0; cnt_clr <= 1'b0; stat_clr <= 1'b0;
    end else begin
      cnt_wr <= 1'b0; cnt_clr <= 1'b0; stat_clr <= 1'b0;
      if (!active) begin
        phase <= P_INS; bitc <= '0; miso_r <= 1'b0;
      end else begin
        if (rise) begin
          bitc <= bitc + 3'd1;
          rxb <= byte_in;
        end
        if (last) begin
          case (phase)
            P_INS: begin
              rsel <= isel;
              phase <= P_END;
              case (byte_in[7:6])
                2'b00: case (isel)
                  3'd0: mode0 <= '0;
                  3'd1: mode1 <= '0;
                  3'd2: data_reg <= '0;
                  3'd3: cnt_clr <= 1'b1;
                  3'd4: out_reg <= '0;
                  3'd5: stat_clr <= 1'b1;
                  default: ;
                endcase
                2'b01: if (isel <= 3'd5) begin
                  phase <= P_RD; sh <= rd_al; left <= rd_len;
                end
                2'b10: if (isel <= 3'd3) begin
                  phase <= P_WR; acc <= '0; left <= rd_len;
                end
                default: begin
                  if (isel == 3'd3) begin cnt_wr <= 1'b1; cnt_wdata <= data_reg; end
                  if (isel == 3'd4) out_reg <= cnt_in;
                end
              endcase
            end
            P_RD: begin
              left <= left - CW'(1);
              if (left == CW'(1)) phase <= P_END;
            end
            P_WR: begin
              acc <= wacc;
              left <= left - CW'(1);
              if (left == CW'(1)) begin
                phase <= P_END;
                case (rsel)
                  3'd0: mode0 <= byte_in;
                  3'd1: mode1 <= byte_in;
                  3'd2: data_reg <= wacc;
                  default: begin cnt_wr <= 1'b1; cnt_wdata <= wacc; end
                endcase
              end
            end
            default: ;
          endcase
        end
        if (fall) begin
          if (phase == P_RD) begin
            miso_r <= sh[DW-1];
            sh <= sh << 1;
          end else miso_r <= 1'b0;
        end
      end
    end
  end

  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !miso); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_wr, cnt_clr, stat_clr})); // R8
  AST_CNT_WR_AT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> $past(rise)); // R4
  AST_MODE_AT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> ($stable(mode1) && $stable(mode0))); // R4
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_RD) |=> ($stable(data_reg) && $stable(mode0) && $stable(mode1) && !cnt_wr)); // R6
endmodule

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
  localparam int HP = 8;
  localparam int NV = 30;
  // {instr, tx data, data byte count, requirement, expected rx}
  localparam logic [78:0] VEC [NV] = '{
    {8'h90, 32'h11223344, 3'd4, 4'd4,  32'h00000000}, // R4 write data
    {8'h50, 32'h00000000, 3'd4, 4'd1,  32'h11223344}, // R1 msb first read
    {8'h80, 32'h5A000000, 3'd1, 4'd2,  32'h00000000}, // R2
    {8'h40, 32'h00000000, 3'd1, 4'd2,  32'h5A000000}, // R2
    {8'h68, 32'h00000000, 3'd1, 4'd3,  32'hA5000000}, // R3 status one byte
    {8'hD8, 32'h00000000, 3'd0, 4'd7,  32'h00000000}, // R7 load counter
    {8'h58, 32'h00000000, 3'd4, 4'd7,  32'h11223344}, // R7
    {8'hE0, 32'h00000000, 3'd0, 4'd7,  32'h00000000}, // R7 load output
    {8'h98, 32'hDEADBEEF, 3'd4, 4'd4,  32'h00000000}, // R4 counter write
    {8'h58, 32'h00000000, 3'd4, 4'd4,  32'hDEADBEEF}, // R4
    {8'h60, 32'h00000000, 3'd4, 4'd7,  32'h11223344}, // R7
    {8'h88, 32'h02000000, 3'd1, 4'd3,  32'h00000000}, // R3 width 2
    {8'h50, 32'h00000000, 3'd2, 4'd3,  32'h33440000}, // R3
    {8'h90, 32'hABCD0000, 3'd2, 4'd3,  32'h00000000}, // R3
    {8'h50, 32'hFFFFFFFF, 3'd4, 4'd5,  32'hABCD0000}, // R5 extra bytes read zero
    {8'h88, 32'h01000000, 3'd1, 4'd3,  32'h00000000}, // R3 width 3
    {8'h58, 32'h00000000, 3'd3, 4'd3,  32'hADBEEF00}, // R3
    {8'h88, 32'h03000000, 3'd1, 4'd3,  32'h00000000}, // R3 width 1
    {8'h60, 32'h00000000, 3'd1, 4'd3,  32'h44000000}, // R3
    {8'h18, 32'h00000000, 3'd0, 4'd8,  32'h00000000}, // R8 clear counter
    {8'h58, 32'h00000000, 3'd1, 4'd8,  32'h00000000}, // R8
    {8'h88, 32'h00000000, 3'd1, 4'd3,  32'h00000000}, // R3 width 4
    {8'h50, 32'h00000000, 3'd4, 4'd6,  32'h0000ABCD}, // R6 mosi ignored
    {8'h80, 32'h77990000, 3'd2, 4'd5,  32'h00000000}, // R5 second byte ignored
    {8'h40, 32'h00000000, 3'd1, 4'd5,  32'h77000000}, // R5
    {8'h00, 32'h00000000, 3'd0, 4'd8,  32'h00000000}, // R8 clear mode0
    {8'h47, 32'h00000000, 3'd1, 4'd8,  32'h00000000}, // R8, low bits ignored
    {8'hA0, 32'h12345678, 3'd4, 4'd4,  32'h00000000}, // R4 output not writable
    {8'h60, 32'h00000000, 3'd4, 4'd4,  32'h11223344}, // R4
    {8'h70, 32'h00000000, 3'd1, 4'd2,  32'h00000000}  // R2 unused target
  };

  logic clk = 1'b0, rst_n = 1'b0, ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, cnt_wr, cnt_clr, stat_clr;
  logic [7:0] mode0, mode1;
  logic [31:0] data_reg, out_reg, cnt_wdata, cnt_model = '0, poke_val = '0, cnt_in;
  logic poke_en = 1'b0, poke_now = 1'b0;
  int total = 0, bad = 0, nstat = 0;

  always #10 clk = ~clk;

  assign cnt_in = poke_now ? poke_val : cnt_model;
  always @(posedge clk) begin
    if (cnt_clr) cnt_model <= '0;
    else if (cnt_wr) cnt_model <= cnt_wdata;
    if (stat_clr) nstat <= nstat + 1;
  end

  spi_cmd_slave dut (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .cnt_in(cnt_in), .status_in(8'hA5),
    .mode0(mode0), .mode1(mode1), .data_reg(data_reg), .out_reg(out_reg),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_clr(cnt_clr), .stat_clr(stat_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] ins, input logic [31:0] tx, input int nd,
                      output logic [31:0] rx);
    logic [31:0] acc = '0;
    logic [7:0] b;
    ss_n = 1'b0;
    wclk(HP);
    for (int i = 0; i <= nd; i++) begin
      b = (i == 0) ? ins : tx[31 - 8*(i-1) -: 8];
      for (int k = 7; k >= 0; k--) begin
        mosi = b[k];
        wclk(HP);
        if (i > 0) acc = {acc[30:0], miso};
        sck = 1'b1;
        wclk(HP);
        sck = 1'b0;
      end
      if (i == 0 && poke_en) poke_now = 1'b1;
    end
    wclk(HP);
    ss_n = 1'b1;
    wclk(2 * HP);
    poke_now = 1'b0;
    rx = (nd == 0) ? 32'h0 : (acc << (32 - 8*nd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    logic [31:0] r;
    wclk(4);
    rst_n = 1'b1;
    wclk(4);
    chk("R10 reset miso_oe", {31'd0, miso_oe}, 32'd0);
    chk("R10 reset miso", {31'd0, miso}, 32'd0);
    chk("R10 reset mode regs", {16'd0, mode0, mode1}, 32'd0);
    chk("R10 reset data", data_reg, 32'd0);
    chk("R10 reset output", out_reg, 32'd0);

    ss_n = 1'b0;
    wclk(HP);
    chk("R9 select active enables miso", {31'd0, miso_oe}, 32'd1);
    ss_n = 1'b1;
    wclk(HP);

    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][78:71], VEC[v][70:39], int'(VEC[v][38:36]), r);
      chk($sformatf("R%0d vector %0d", VEC[v][35:32], v), r, VEC[v][31:0]);
    end

    chk("R9 idle miso_oe", {31'd0, miso_oe}, 32'd0);
    chk("R9 idle miso", {31'd0, miso}, 32'd0);
    chk("R8 mode0 cleared", {24'd0, mode0}, 32'd0);
    chk("R3 mode1 port", {24'd0, mode1}, 32'd0);

    xfer(8'h90, 32'h55555555, 2, r);
    chk("R4 truncated write", data_reg, 32'h0000ABCD);

    xfer(8'h98, 32'h01020304, 4, r);
    poke_val = 32'hFFFFFFFF;
    poke_en = 1'b1;
    xfer(8'h58, 32'h0, 4, r);
    poke_en = 1'b0;
    chk("R6 snapshot read", r, 32'h01020304);

    xfer(8'h28, 32'h0, 0, r);
    chk("R8 status clear pulses", nstat, 1);

    xfer(8'h10, 32'h0, 0, r);
    chk("R8 clear data", data_reg, 32'h0);

    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule